// File: doc/BRIEF.md
# Dual-Address Synchronous SRAM with Cross-Port Pass-Through

This block is a two-port synchronous memory. Ports X and Y each have an address, an active-low write strobe, an active-low pass-through strobe, an active-low output enable, and a data bus. Each data bus is split into an input, an output and a drive-enable. Both ports share one clock and two chip-select inputs. One select is active low and the other is active high. All synchronous inputs are captured on the rising clock edge. The array is accessed one cycle later, and each port's result is loaded into that port's output register.

Pass-through sends a port's captured input word to the opposite port's output register. It uses the same one-cycle path as a read, and it overrides a read on the receiving port. When both ports name the same word in one cycle, the outcome is fixed:
- Two reads both return the stored word.
- When one port reads and the other writes, the reader sees the old contents.
- When both ports write, only port Y's word is kept.

The depth defaults to 1K words, which keeps elaboration small. Setting `ADDR_W` to 16 gives the full 64K x 18 organisation.

Top module: `dual_addr_sram`

## Requirements
- R1: An operation takes place only when `selN`=0 and `selP`=1 at the clock edge. On a deselected edge nothing is written, and both output registers keep their values through the following edge.
- R2: Address, data and strobes are captured at edge n. The resulting word appears on `xDataOut`/`yDataOut` after edge n+1 and not before.
- R3: `xDataOe`/`yDataOe` are 1 exactly while `xOutEnN`/`yOutEnN` are 0. They follow that input with no clock involved.
- R4: A port with write strobe 0 stores its input word at its address. Both ports may write different addresses in the same cycle.
- R5: `xPassN`=0 loads port X's input word into port Y's output register, and `yPassN`=0 loads port Y's word into port X's output register. This happens with read latency, overrides a read on the receiving port, and may be combined with writes and with the other pass.
- R6: A port reads only when its write strobe and its own pass strobe are both 1 and no pass is aimed at it. Otherwise, with no incoming pass, its output register holds.
- R7: Two reads of the same address in one cycle both return the stored word.
- R8: When one port writes and the other reads the same address in one cycle, the reader gets the previous contents, and later reads get the new word.
- R9: When both ports write the same address in one cycle, port Y's word is stored.
- R10: `rstN`=0 clears both output registers at once and cancels every operation captured but not yet performed. It does not clear the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset of control and output registers |
| selN | input | 1 | Active-low chip select |
| selP | input | 1 | Active-high chip select |
| xAddr | input | ADDR_W | Port X word address |
| xWriteN | input | 1 | Port X write strobe, active low |
| xPassN | input | 1 | Pass port X input to port Y output, active low |
| xOutEnN | input | 1 | Port X output enable, active low, asynchronous |
| xDataIn | input | DATA_W | Port X write / pass data |
| xDataOut | output | DATA_W | Port X output register |
| xDataOe | output | 1 | Port X bus drive enable |
| yAddr | input | ADDR_W | Port Y word address |
| yWriteN | input | 1 | Port Y write strobe, active low |
| yPassN | input | 1 | Pass port Y input to port X output, active low |
| yOutEnN | input | 1 | Port Y output enable, active low, asynchronous |
| yDataIn | input | DATA_W | Port Y write / pass data |
| yDataOut | output | DATA_W | Port Y output register |
| yDataOe | output | 1 | Port Y bus drive enable |

## Verification
The hardest case to reach is a reset that lands between the capture edge of a write and the edge that would perform it. The bench raises the write at a falling edge and lets one rising edge capture it. It then pulls `rstN` low on the next falling edge, so that the second rising edge sees reset. A read of that address after release must return the old word. Same-address collisions are reached by driving both ports with identical addresses in one cycle. The old and new contents are always chosen to differ, so a read-before-write ordering error shows up as a wrong value.

// File: rtl/dasram_pkg.sv
package dasram_pkg;

  // Source selected for a port's output register at the execute edge
  typedef enum logic [1:0] {
    OUT_HOLD  = 2'd0,
    OUT_ARRAY = 2'd1,
    OUT_PASS  = 2'd2
  } outSrc_e;

  // Strobes from control to datapath for the cycle being executed
  typedef struct packed {
    logic    wrX;
    logic    wrY;
    outSrc_e srcX;
    outSrc_e srcY;
  } strobes_t;

endpackage

// File: rtl/dasram_ctrl.sv
module dasram_ctrl
  import dasram_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     selN,
  input  logic     selP,
  input  logic     xWriteN,
  input  logic     yWriteN,
  input  logic     xPassN,
  input  logic     yPassN,
  input  logic     sameAddr,
  output strobes_t strb
);

  // Captured controls, stored active high
  logic selQ, wrXQ, wrYQ, passXQ, passYQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ   <= 1'b0;
      wrXQ   <= 1'b0;
      wrYQ   <= 1'b0;
      passXQ <= 1'b0;
      passYQ <= 1'b0;
    end else begin
      selQ   <= !selN && selP;
      wrXQ   <= !xWriteN;
      wrYQ   <= !yWriteN;
      passXQ <= !xPassN;
      passYQ <= !yPassN;
    end
  end

  logic    doWrY, doWrX;
  outSrc_e srcX, srcY;

  always_comb begin
    doWrY = selQ && wrYQ;
    // port Y wins a same-address double write
    doWrX = selQ && wrXQ && !(doWrY && sameAddr);

    if (selQ && passYQ)                 srcX = OUT_PASS;
    else if (selQ && !wrXQ && !passXQ)  srcX = OUT_ARRAY;
    else                                srcX = OUT_HOLD;

    if (selQ && passXQ)                 srcY = OUT_PASS;
    else if (selQ && !wrYQ && !passYQ)  srcY = OUT_ARRAY;
    else                                srcY = OUT_HOLD;

    strb.wrX  = doWrX;
    strb.wrY  = doWrY;
    strb.srcX = srcX;
    strb.srcY = srcY;
  end

endmodule

// File: rtl/dasram_datapath.sv
module dasram_datapath
  import dasram_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] xAddr,
  input  logic [ADDR_W-1:0] yAddr,
  input  logic [DATA_W-1:0] xDataIn,
  input  logic [DATA_W-1:0] yDataIn,
  input  strobes_t          strb,
  output logic              sameAddr,
  output logic [DATA_W-1:0] xOutQ,
  output logic [DATA_W-1:0] yOutQ
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] xAddrQ, yAddrQ;
  logic [DATA_W-1:0] xDinQ, yDinQ;

  always_ff @(posedge clk) begin
    xAddrQ <= xAddr;
    yAddrQ <= yAddr;
    xDinQ  <= xDataIn;
    yDinQ  <= yDataIn;
  end

  assign sameAddr = (xAddrQ == yAddrQ);

  // Array update; control never raises both strobes on one address
  always_ff @(posedge clk) begin
    if (strb.wrX) mem[xAddrQ] <= xDinQ;
    if (strb.wrY) mem[yAddrQ] <= yDinQ;
  end

  // Output registers read the array before this edge's writes land
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xOutQ <= '0;
      yOutQ <= '0;
    end else begin
      case (strb.srcX)
        OUT_ARRAY: xOutQ <= mem[xAddrQ];
        OUT_PASS:  xOutQ <= yDinQ;
        default:   xOutQ <= xOutQ;
      endcase
      case (strb.srcY)
        OUT_ARRAY: yOutQ <= mem[yAddrQ];
        OUT_PASS:  yOutQ <= xDinQ;
        default:   yOutQ <= yOutQ;
      endcase
    end
  end

endmodule

// File: rtl/dual_addr_sram.sv
module dual_addr_sram
  import dasram_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              selP,
  input  logic [ADDR_W-1:0] xAddr,
  input  logic              xWriteN,
  input  logic              xPassN,
  input  logic              xOutEnN,
  input  logic [DATA_W-1:0] xDataIn,
  output logic [DATA_W-1:0] xDataOut,
  output logic              xDataOe,
  input  logic [ADDR_W-1:0] yAddr,
  input  logic              yWriteN,
  input  logic              yPassN,
  input  logic              yOutEnN,
  input  logic [DATA_W-1:0] yDataIn,
  output logic [DATA_W-1:0] yDataOut,
  output logic              yDataOe
);

  strobes_t strb;
  logic     sameAddr;

  dasram_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .selN    (selN),
    .selP    (selP),
    .xWriteN (xWriteN),
    .yWriteN (yWriteN),
    .xPassN  (xPassN),
    .yPassN  (yPassN),
    .sameAddr(sameAddr),
    .strb    (strb)
  );

  dasram_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .xAddr   (xAddr),
    .yAddr   (yAddr),
    .xDataIn (xDataIn),
    .yDataIn (yDataIn),
    .strb    (strb),
    .sameAddr(sameAddr),
    .xOutQ   (xDataOut),
    .yOutQ   (yDataOut)
  );

  // Output enables bypass the clock entirely
  assign xDataOe = !xOutEnN;
  assign yDataOe = !yOutEnN;

endmodule

// File: rtl/dasram_checker.sv
module dasram_checker #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic              selP,
  input logic              xWriteN,
  input logic              yWriteN,
  input logic              xPassN,
  input logic              yPassN,
  input logic [DATA_W-1:0] xDataIn,
  input logic [DATA_W-1:0] yDataIn,
  input logic [DATA_W-1:0] xDataOut,
  input logic [DATA_W-1:0] yDataOut
);

  assert_deselect_hold_x_R1: assert property (@(posedge clk) disable iff (!rstN)
    (selN || !selP) |=> ##1 $stable(xDataOut));

  assert_deselect_hold_y_R1: assert property (@(posedge clk) disable iff (!rstN)
    (selN || !selP) |=> ##1 $stable(yDataOut));

  assert_pass_y_to_x_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && selP && !yPassN) |=> ##1 (xDataOut == $past(yDataIn, 2)));

  assert_pass_x_to_y_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && selP && !xPassN) |=> ##1 (yDataOut == $past(xDataIn, 2)));

  assert_writer_hold_x_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && selP && !xWriteN && yPassN) |=> ##1 $stable(xDataOut));

  assert_writer_hold_y_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && selP && !yWriteN && xPassN) |=> ##1 $stable(yDataOut));

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rstN |=> (xDataOut == '0 && yDataOut == '0));

endmodule

bind dual_addr_sram dasram_checker #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .selN    (selN),
  .selP    (selP),
  .xWriteN (xWriteN),
  .yWriteN (yWriteN),
  .xPassN  (xPassN),
  .yPassN  (yPassN),
  .xDataIn (xDataIn),
  .yDataIn (yDataIn),
  .xDataOut(xDataOut),
  .yDataOut(yDataOut)
);

// File: tb/dual_addr_sram_tb.sv
module dual_addr_sram_tb;

  localparam int CLK_P = 10;
  localparam int DW    = 18;
  localparam int AW    = 10;

  logic          clk = 1'b0;
  logic          rstN;
  logic          selN, selP;
  logic [AW-1:0] xAddr, yAddr;
  logic          xWriteN, yWriteN, xPassN, yPassN, xOutEnN, yOutEnN;
  logic [DW-1:0] xDataIn, yDataIn;
  logic [DW-1:0] xDataOut, yDataOut;
  logic          xDataOe, yDataOe;

  logic [DW-1:0] refMem [1 << AW];
  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_P/2) clk = !clk;

  dual_addr_sram #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .selN(selN), .selP(selP),
    .xAddr(xAddr), .xWriteN(xWriteN), .xPassN(xPassN), .xOutEnN(xOutEnN),
    .xDataIn(xDataIn), .xDataOut(xDataOut), .xDataOe(xDataOe),
    .yAddr(yAddr), .yWriteN(yWriteN), .yPassN(yPassN), .yOutEnN(yOutEnN),
    .yDataIn(yDataIn), .yDataOut(yDataOut), .yDataOe(yDataOe)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic setIdle();
    selN = 1'b1; selP = 1'b1;
    xWriteN = 1'b1; yWriteN = 1'b1; xPassN = 1'b1; yPassN = 1'b1;
  endtask

  // Drive one cycle at a falling edge, then idle; returns after the execute edge
  task automatic op(input logic sN, input logic sP,
                    input logic xw, input logic yw, input logic xp, input logic yp,
                    input logic [AW-1:0] xa, input logic [AW-1:0] ya,
                    input logic [DW-1:0] xd, input logic [DW-1:0] yd);
    selN = sN; selP = sP;
    xWriteN = xw; yWriteN = yw; xPassN = xp; yPassN = yp;
    xAddr = xa; yAddr = ya; xDataIn = xd; yDataIn = yd;
    @(negedge clk);
    setIdle();
    @(negedge clk);
  endtask

  task automatic readBoth(input logic [AW-1:0] xa, input logic [AW-1:0] ya);
    op(0, 1, 1, 1, 1, 1, xa, ya, '0, '0);
  endtask

  task automatic testResetAndOe();
    chk("R10 reset x", xDataOut, '0);
    chk("R10 reset y", yDataOut, '0);
    xOutEnN = 1'b0; yOutEnN = 1'b1; #1;
    chk("R3 oe x on", DW'(xDataOe), DW'(1));
    chk("R3 oe y off", DW'(yDataOe), DW'(0));
    xOutEnN = 1'b1; yOutEnN = 1'b0; #1;
    chk("R3 oe x off", DW'(xDataOe), DW'(0));
    chk("R3 oe y on", DW'(yDataOe), DW'(1));
  endtask

  task automatic testFillAndRead();
    for (int i = 0; i < 8; i++) begin
      logic [DW-1:0] dx, dy;
      dx = DW'(18'h0155 + i * 37);
      dy = DW'(18'h2a0c + i * 91);
      op(0, 1, 0, 0, 1, 1, AW'(i), AW'(i + 16), dx, dy);
      refMem[i] = dx; refMem[i + 16] = dy;
      chk("R6 writers hold x", xDataOut, '0);
      chk("R6 writers hold y", yDataOut, '0);
    end
    // exact latency: nothing after capture edge, result after execute edge
    selN = 0; selP = 1; xAddr = AW'(2); yAddr = AW'(18);
    @(negedge clk); setIdle();
    chk("R2 not yet x", xDataOut, '0);
    @(negedge clk);
    chk("R2 latency x", xDataOut, refMem[2]);
    chk("R2 latency y", yDataOut, refMem[18]);
    for (int i = 0; i < 8; i++) begin
      readBoth(AW'(7 - i), AW'(16 + i));
      chk("R4 readback x", xDataOut, refMem[7 - i]);
      chk("R4 readback y", yDataOut, refMem[16 + i]);
    end
  endtask

  task automatic testCollisions();
    readBoth(AW'(4), AW'(4));
    chk("R7 same read x", xDataOut, refMem[4]);
    chk("R7 same read y", yDataOut, refMem[4]);
    // X writes, Y reads the same word
    op(0, 1, 0, 1, 1, 1, AW'(3), AW'(3), 18'h3_1111, '0);
    chk("R8 y gets old", yDataOut, refMem[3]);
    refMem[3] = 18'h3_1111;
    readBoth(AW'(3), AW'(3));
    chk("R8 new stored", yDataOut, refMem[3]);
    // Y writes, X reads the same word
    op(0, 1, 1, 0, 1, 1, AW'(5), AW'(5), '0, 18'h2_2222);
    chk("R8 x gets old", xDataOut, refMem[5]);
    refMem[5] = 18'h2_2222;
    readBoth(AW'(5), AW'(0));
    chk("R8 new stored x", xDataOut, refMem[5]);
    // both write the same word
    op(0, 1, 0, 0, 1, 1, AW'(6), AW'(6), 18'h0_aaaa, 18'h1_bbbb);
    refMem[6] = 18'h1_bbbb;
    readBoth(AW'(6), AW'(6));
    chk("R9 y wins x", xDataOut, 18'h1_bbbb);
    chk("R9 y wins y", yDataOut, 18'h1_bbbb);
  endtask

  task automatic testPass();
    logic [DW-1:0] yHeld;
    // X writes and passes to Y, Y otherwise would read
    op(0, 1, 0, 1, 0, 1, AW'(9), AW'(1), 18'h0_9999, '0);
    refMem[9] = 18'h0_9999;
    chk("R5 pass x->y", yDataOut, 18'h0_9999);
    readBoth(AW'(9), AW'(2));
    chk("R5 write with pass", xDataOut, refMem[9]);
    yHeld = yDataOut;
    // Y passes to X while X is set to read
    op(0, 1, 1, 1, 1, 0, AW'(1), AW'(17), '0, 18'h1_2345);
    chk("R5 pass beats read", xDataOut, 18'h1_2345);
    chk("R6 y no read while passing", yDataOut, yHeld);
    // both passes at once
    op(0, 1, 1, 1, 0, 0, AW'(0), AW'(0), 18'h0_0f0f, 18'h3_f0f0);
    chk("R5 swap x", xDataOut, 18'h3_f0f0);
    chk("R5 swap y", yDataOut, 18'h0_0f0f);
  endtask

  task automatic testDeselect();
    logic [DW-1:0] xh, yh;
    xh = xDataOut; yh = yDataOut;
    op(1, 1, 0, 0, 0, 0, AW'(0), AW'(1), 18'h3_3333, 18'h3_4444);
    chk("R1 selN high hold x", xDataOut, xh);
    chk("R1 selN high hold y", yDataOut, yh);
    op(0, 0, 0, 0, 0, 0, AW'(0), AW'(1), 18'h3_5555, 18'h3_6666);
    chk("R1 selP low hold x", xDataOut, xh);
    readBoth(AW'(0), AW'(1));
    chk("R1 no write x", xDataOut, refMem[0]);
    chk("R1 no write y", yDataOut, refMem[1]);
  endtask

  task automatic testMidReset();
    selN = 0; selP = 1; xWriteN = 0; xAddr = AW'(7); xDataIn = 18'h2_7777;
    yPassN = 0; yDataIn = 18'h1_0001;
    @(negedge clk);
    setIdle();
    rstN = 1'b0;
    #1;
    chk("R10 async clear x", xDataOut, '0);
    @(negedge clk);
    chk("R10 pass cancelled", xDataOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    readBoth(AW'(7), AW'(16));
    chk("R10 write cancelled", xDataOut, refMem[7]);
    chk("R10 array kept", yDataOut, refMem[16]);
  endtask

  initial begin
    #(CLK_P * 20000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b1;
    setIdle();
    xOutEnN = 1'b0; yOutEnN = 1'b0;
    xAddr = '0; yAddr = '0; xDataIn = '0; yDataIn = '0;
    #2 rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testResetAndOe();
    testFillAndRead();
    testCollisions();
    testPass();
    testDeselect();
    testMidReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule